// File: doc/BRIEF.md
# Programmable Bus Address Trap Unit

This block watches a stream of bus cycles and flags any cycle that falls inside one of two programmable trap windows. Each trap has a 30-bit word address, a flag choosing I/O or memory space, an enable and a three-bit mask. Each mask bit widens the window by dropping one of address bits 5:3 from the comparison. A qualified match sets a sticky per-trap status flag and a shared trap-event bit in a device status register. Software clears both by writing ones to them.

A 16-line interrupt-request enable register selects which request lines count. While any enabled line is pending, a second device status bit is set. Either device status bit can pull the active-low system-management interrupt output low, if its own enable bit in the device control register is set. Software reaches all registers through a synchronous write port and a combinational read port at fixed byte offsets.

Top module: `addr_trap_unit`

## Requirements
- R1: After reset every register reads 0 and `smi_n` is 1.
- R2: A trap register (trap 0 at offset 0x38, trap 1 at 0x44) holds the compare address in bits 31:2, a status flag in bit 1 and a space bit in bit 0, where 1 means I/O space and 0 means memory space. Software writes load the address and the space bit. A write never sets the status flag.
- R3: An enabled trap matches a bus cycle whose address bits 31:2 equal its own. Address bits 1:0 are ignored. A disabled trap never matches.
- R4: A cycle matches only when `bus_is_io` equals the trap's space bit.
- R5: Device control bits 3:1 (trap 0) and 7:5 (trap 1) mask address bits 5:3, with the lowest mask bit covering address bit 3. A masked bit is left out of the comparison.
- R6: The status flag sets on the clock edge that samples a match. Writing 1 to bit 1 clears it. Writing 0 to bit 1 leaves it unchanged.
- R7: If a match and a clearing write land on the same edge, the status flag ends up set.
- R8: A match on either trap sets bit 10 of the device status register (offset 0x48) on the same edge. Writing 1 to that bit clears it.
- R9: The register at offset 0x40 holds one enable bit per request line in bits 15:0; its bits 31:16 read 0. While `irq_req & enables` is nonzero, bit 11 of the device status register sets. Bit 11 is cleared by writing 1 to it. Requests on lines that are not enabled are ignored.
- R10: `smi_n` goes low one edge after device status bit 10 or 11 is set, provided that its enable is set. The enable for status bit k is device control bit 8+k. With the enable clear, `smi_n` stays high.
- R11: `smi_n` returns high one edge after the last enabled status bit is cleared.
- R12: Device control (offset 0x3C) bit 0 enables trap 0 and bit 4 enables trap 1. All 32 bits read back as written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| irq_req | input | 16 | Pending interrupt-request lines |
| smi_n | output | 1 | Active-low management interrupt |

## Verification
Trap status flags and device status bits change on the first edge after the stimulus that causes them, whether a bus cycle or a pending request. `smi_n` follows one edge later, and a clearing write releases it one edge after the write is taken. Register reads are combinational and show the value in the same cycle. The bench drives every input on a falling edge and samples on the following falling edge. Each latency is checked on both sides: the bench first confirms the old value one cycle early, then the new value.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int ADDR_W   = 32;
  localparam int REG_AW   = 8;
  localparam int N_TRAPS  = 2;
  localparam int MASK_LO  = 3;
  localparam int MASK_W   = 3;
  localparam int N_IRQ    = 16;
  localparam int STS_TRAP = 10;
  localparam int STS_IRQ  = 11;
  localparam int SMI_EN_BASE = 8;

  localparam logic [REG_AW-1:0] OFF_TRAP0  = 8'h38;
  localparam logic [REG_AW-1:0] OFF_DEVCTL = 8'h3C;
  localparam logic [REG_AW-1:0] OFF_IRQEN  = 8'h40;
  localparam logic [REG_AW-1:0] OFF_TRAP1  = 8'h44;
  localparam logic [REG_AW-1:0] OFF_DEVSTS = 8'h48;

  function automatic logic [REG_AW-1:0] trap_off(input int idx);
    return (idx == 0) ? OFF_TRAP0 : OFF_TRAP1;
  endfunction

  // Bits taking part in a compare: 31:2 minus any masked bit of 5:3.
  function automatic logic [ADDR_W-1:0] care_bits(input logic [MASK_W-1:0] msk);
    logic [ADDR_W-1:0] c;
    c = {{(ADDR_W-2){1'b1}}, 2'b00};
    for (int b = 0; b < MASK_W; b++)
      if (msk[b]) c[MASK_LO+b] = 1'b0;
    return c;
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] tgt,
                                    input logic a_io, input logic tgt_io,
                                    input logic [MASK_W-1:0] msk);
    return (((a ^ tgt) & care_bits(msk)) == '0) && (a_io == tgt_io);
  endfunction
endpackage

// File: rtl/atu_trap_slot.sv
module atu_trap_slot
  import atu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic              trap_en,
  input  logic [MASK_W-1:0] mask,
  output logic [31:0]       reg_value,
  output logic              hit
);
  logic [ADDR_W-3:0] addr_q;
  logic              io_q;
  logic              sts_q;
  logic              sw_clear;

  assign hit      = trap_en && bus_valid &&
                    addr_hit(bus_addr, {addr_q, 2'b00}, bus_is_io, io_q, mask);
  assign sw_clear = wr_en && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      io_q   <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        addr_q <= wdata[31:2];
        io_q   <= wdata[0];
      end
      if (hit)           sts_q <= 1'b1;
      else if (sw_clear) sts_q <= 1'b0;
    end
  end

  assign reg_value = {addr_q, sts_q, io_q};

  assert_sts_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts_q);
  assert_write0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[1] && sts_q) |=> sts_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sw_clear) |=> sts_q);
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_en && !sw_clear && !sts_q) |=> !sts_q);
endmodule

// File: rtl/atu_irq_fold.sv
module atu_irq_fold
  import atu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_IRQ-1:0] wdata,
  input  logic [N_IRQ-1:0] irq_req,
  output logic [N_IRQ-1:0] en_value,
  output logic             pend
);
  logic [N_IRQ-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata;
  end

  assign en_value = en_q;
  assign pend     = |(irq_req & en_q);

  assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_value == $past(wdata)));
endmodule

// File: rtl/atu_smi_gen.sv
module atu_smi_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wclr,
  input  logic       trap_evt,
  input  logic       irq_evt,
  input  logic [1:0] smi_en,
  output logic [1:0] sts_value,
  output logic       smi_n
);
  logic [1:0] sts_q;
  logic [1:0] set_v;
  logic       smi_n_q;
  logic       want_smi;

  assign set_v    = {irq_evt, trap_evt};
  assign want_smi = |(sts_q & smi_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      smi_n_q <= 1'b1;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (set_v[k])                 sts_q[k] <= 1'b1;
        else if (wr_en && wclr[k])    sts_q[k] <= 1'b0;
      end
      smi_n_q <= !want_smi;
    end
  end

  assign sts_value = sts_q;
  assign smi_n     = smi_n_q;

  assert_trap_sts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> sts_value[0]);
  assert_irq_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> sts_value[1]);
  assert_smi_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_value & smi_en)) |=> !smi_n);
  assert_smi_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_value & smi_en)) |=> smi_n);
endmodule

// File: rtl/addr_trap_unit.sv
module addr_trap_unit
  import atu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic [N_IRQ-1:0]  irq_req,
  output logic              smi_n
);
  localparam int CTL_STRIDE = 1 + MASK_W;

  logic [31:0]      devctl_q;
  logic [31:0]      trap_val [N_TRAPS];
  logic [N_TRAPS-1:0] trap_hit;
  logic [N_IRQ-1:0] irq_en_val;
  logic             irq_pend;
  logic [1:0]       dev_sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 devctl_q <= '0;
    else if (reg_wen && reg_addr == OFF_DEVCTL) devctl_q <= reg_wdata;
  end

  for (genvar i = 0; i < N_TRAPS; i++) begin : g_trap
    atu_trap_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wen && reg_addr == trap_off(i)),
      .wdata     (reg_wdata),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_is_io (bus_is_io),
      .trap_en   (devctl_q[CTL_STRIDE*i]),
      .mask      (devctl_q[CTL_STRIDE*i+1 +: MASK_W]),
      .reg_value (trap_val[i]),
      .hit       (trap_hit[i])
    );
  end

  atu_irq_fold u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wen && reg_addr == OFF_IRQEN),
    .wdata    (reg_wdata[N_IRQ-1:0]),
    .irq_req  (irq_req),
    .en_value (irq_en_val),
    .pend     (irq_pend)
  );

  atu_smi_gen u_smi (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wen && reg_addr == OFF_DEVSTS),
    .wclr      (reg_wdata[STS_IRQ:STS_TRAP]),
    .trap_evt  (|trap_hit),
    .irq_evt   (irq_pend),
    .smi_en    (devctl_q[SMI_EN_BASE+STS_IRQ:SMI_EN_BASE+STS_TRAP]),
    .sts_value (dev_sts),
    .smi_n     (smi_n)
  );

  always_comb begin
    unique case (reg_addr)
      OFF_TRAP0:  reg_rdata = trap_val[0];
      OFF_TRAP1:  reg_rdata = trap_val[1];
      OFF_DEVCTL: reg_rdata = devctl_q;
      OFF_IRQEN:  reg_rdata = {{(32-N_IRQ){1'b0}}, irq_en_val};
      OFF_DEVSTS: reg_rdata = {{(32-STS_IRQ-1){1'b0}}, dev_sts, {STS_TRAP{1'b0}}};
      default:    reg_rdata = '0;
    endcase
  end

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h50) |-> (reg_rdata == '0));
  assert_smi_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> smi_n);
endmodule

// File: tb/addr_trap_unit_tb.sv
module addr_trap_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_is_io = 1'b0;
  logic [15:0] irq_req = '0;
  logic        smi_n;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_is_io(bus_is_io), .irq_req(irq_req), .smi_n(smi_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic bus(input logic [31:0] a, input logic io);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_is_io = io;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] st(input logic [31:0] v);
    return (v >> 1) & 32'h1;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h38, v); chk("R1 trap0", v, 0);
    rd(8'h3C, v); chk("R1 devctl", v, 0);
    rd(8'h40, v); chk("R1 irqen", v, 0);
    rd(8'h44, v); chk("R1 trap1", v, 0);
    rd(8'h48, v); chk("R1 devsts", v, 0);
    chk("R1 smi_n", smi_n, 1);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h38, 32'hABCD_1237); rd(8'h38, v); chk("R2 trap0 readback", v, 32'hABCD_1235);
    wr(8'h44, 32'h0000_5670); rd(8'h44, v); chk("R2 trap1 readback", v, 32'h0000_5670);
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, v); chk("R12 devctl readback", v, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R12 irqen upper zero", v, 32'h0000_FFFF);
    rd(8'h50, v); chk("R12 unmapped", v, 0);
    wr(8'h3C, 0); wr(8'h40, 0);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(8'h38, 32'h0000_1000); wr(8'h3C, 32'h1);
    bus(32'h0000_1003, 1'b0); rd(8'h38, v); chk("R3 low bits ignored", st(v), 1);
    wr(8'h38, 32'h0000_1002);
    bus(32'h0000_1004, 1'b0); rd(8'h38, v); chk("R3 other word no hit", st(v), 0);
    wr(8'h3C, 32'h0);
    bus(32'h0000_1000, 1'b0); rd(8'h38, v); chk("R3 disabled no hit", st(v), 0);
  endtask

  task automatic t_space();
    logic [31:0] v;
    wr(8'h38, 32'h0000_0201); wr(8'h3C, 32'h1);
    bus(32'h0000_0200, 1'b0); rd(8'h38, v); chk("R4 mem vs io no hit", st(v), 0);
    bus(32'h0000_0200, 1'b1); rd(8'h38, v); chk("R4 io hit", st(v), 1);
    wr(8'h38, 32'h0000_0203);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h38, 32'h0000_1000); wr(8'h3C, 32'hF);
    bus(32'h0000_1038, 1'b0); rd(8'h38, v); chk("R5 all masked hit", st(v), 1);
    wr(8'h38, 32'h0000_1002); wr(8'h3C, 32'h3);
    bus(32'h0000_1010, 1'b0); rd(8'h38, v); chk("R5 bit4 unmasked no hit", st(v), 0);
    bus(32'h0000_1008, 1'b0); rd(8'h38, v); chk("R5 bit3 masked hit", st(v), 1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h38, 32'h0000_1000); rd(8'h38, v); chk("R6 write0 keeps", st(v), 1);
    wr(8'h38, 32'h0000_1002); rd(8'h38, v); chk("R6 write1 clears", st(v), 0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    wr(8'h3C, 32'h1);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 32'h0000_1000; bus_is_io = 1'b0;
    reg_wen = 1'b1; reg_addr = 8'h38; reg_wdata = 32'h0000_1002;
    @(negedge clk);
    bus_valid = 1'b0; reg_wen = 1'b0;
    rd(8'h38, v); chk("R7 set beats clear", st(v), 1);
    wr(8'h38, 32'h0000_1002); wr(8'h48, 32'h0000_0C00);
  endtask

  task automatic t_trap1();
    logic [31:0] v;
    wr(8'h44, 32'h0000_2001); wr(8'h3C, 32'h10);
    bus(32'h0000_2000, 1'b1);
    rd(8'h44, v); chk("R8 trap1 status", st(v), 1);
    rd(8'h48, v); chk("R8 global bit set", v, 32'h0000_0400);
    wr(8'h48, 32'h0000_0400); rd(8'h48, v); chk("R8 global cleared", v, 0);
    wr(8'h44, 32'h0000_2003);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h40, 32'h0010);
    @(negedge clk); irq_req = 16'h0008;
    @(negedge clk); rd(8'h48, v); chk("R9 unenabled line ignored", v, 0);
    irq_req = 16'h0010;
    @(negedge clk); rd(8'h48, v); chk("R9 enabled line sets bit11", v, 32'h0000_0800);
    irq_req = 16'h0;
    wr(8'h48, 32'h0000_0800); rd(8'h48, v); chk("R9 bit11 cleared", v, 0);
  endtask

  task automatic t_smi();
    wr(8'h3C, 32'h1);
    bus(32'h0000_1000, 1'b0);
    @(negedge clk); chk("R10 enable clear keeps smi high", smi_n, 1);
    wr(8'h48, 32'h0000_0400); wr(8'h38, 32'h0000_1002);
    wr(8'h3C, 32'h0004_0001);
    bus(32'h0000_1000, 1'b0);
    chk("R10 smi not yet low", smi_n, 1);
    @(negedge clk); chk("R10 smi low", smi_n, 0);
    wr(8'h48, 32'h0000_0400);
    chk("R11 smi still low at clear edge", smi_n, 0);
    @(negedge clk); chk("R11 smi released", smi_n, 1);
    wr(8'h3C, 32'h0008_0000);
    irq_req = 16'h0010;
    @(negedge clk); irq_req = 16'h0;
    @(negedge clk); chk("R10 irq path smi low", smi_n, 0);
    wr(8'h48, 32'h0000_0800);
    @(negedge clk); chk("R11 irq path released", smi_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_match();
    t_space();
    t_mask();
    t_w1c();
    t_setwins();
    t_trap1();
    t_irq();
    t_smi();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule